// File: doc/BRIEF.md
# Four-Channel DMA Engine

This block moves data for software without processor involvement. It has four channels. Each channel holds a source address, a destination address, a byte count and a set of mode bits. A channel is programmed through a one-cycle configuration write. After that, either a software start pulse or a rising edge on a chosen interrupt request line drives its work.

Every unit of work is one read followed by one write. Both go through a single-master bus port that holds each cycle until the bus grants it. A unit is either one byte or one 16-bit word. Each pointer either stays put or advances by the unit size.

A channel runs in one of two modes. In single mode it moves one unit per trigger. In burst mode it moves its whole count on one trigger and keeps the bus until it has finished. When the count runs out, the channel disables itself, raises a done flag and gives a one-cycle completion pulse.

Top module: `dma4_engine`

## Requirements
- R1: The four channels are programmed independently. A cycle with `cfg_we` high loads the addressed channel's pointers, count, mode bits, request-line select and enable. The same write clears that channel's done flag and any pending trigger.
- R2: When `cfg_hw_trig` is 0, each clock cycle in which `sw_start[i]` is high triggers channel i. Interrupt lines have no effect on such a channel.
- R3: When `cfg_hw_trig` is 1, only a rising edge (0 then 1 on successive clock edges) of `irq_req[sel]` triggers the channel. A line held high triggers once, and other lines and `sw_start` have no effect.
- R4: With `cfg_word` = 1, a unit is a 16-bit word and `bus_word` is 1. With `cfg_word` = 0, a unit is one byte carried on data bits [7:0] and `bus_word` is 0. A word occupies byte address a (bits [7:0]) and a+1 (bits [15:8]).
- R5: `cfg_src_inc` and `cfg_dst_inc` independently choose whether the source and destination pointers stay fixed (0) or advance by the unit size (1 or 2) after each unit.
- R6: Each unit is a read at the source pointer followed by a write of the data read to the destination pointer (`bus_we` 0 then 1).
- R7: While `bus_req` is high and `bus_gnt` is low, the bus cycle is held: `bus_req`, `bus_addr`, `bus_we` and `bus_word` do not change. The read is not treated as done until it is granted.
- R8: With `cfg_burst` = 0, a trigger moves exactly one unit. With `cfg_burst` = 1, a trigger moves the whole count back to back, and no other channel gets the bus until the burst ends.
- R9: Among pending channels, the lowest index wins. Arbitration takes place before every single-mode unit and before every burst.
- R10: The count is in bytes, `CW` bits wide (17 by default). In word mode bit 0 of the loaded count is ignored. A count that is zero after that rounding stands for 2^CW bytes.
- R11: After the final unit, the channel's `chan_en` drops and `chan_done` rises on the same clock edge. `chan_irq` for that channel is high for exactly one cycle at that moment.
- R12: A trigger that arrives while the channel is disabled, whether never enabled or disabled by completion, starts no bus activity.
- R13: After reset, `chan_en`, `chan_done`, `chan_irq` and `bus_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | log2(NCH) | Channel addressed by the write |
| cfg_src | input | AW | Source pointer |
| cfg_dst | input | AW | Destination pointer |
| cfg_cnt | input | CW | Byte count |
| cfg_word | input | 1 | 1 = 16-bit units, 0 = byte units |
| cfg_burst | input | 1 | 1 = burst mode, 0 = single-unit mode |
| cfg_src_inc | input | 1 | 1 = source pointer advances |
| cfg_dst_inc | input | 1 | 1 = destination pointer advances |
| cfg_hw_trig | input | 1 | 1 = interrupt-line trigger, 0 = software trigger |
| cfg_sel | input | log2(NIRQ) | Interrupt line used as the trigger |
| cfg_en | input | 1 | Channel enable |
| sw_start | input | NCH | Software start, one bit per channel |
| irq_req | input | NIRQ | Interrupt request lines |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_word | output | 1 | 1 = 16-bit access, 0 = byte access |
| bus_addr | output | AW | Bus byte address |
| bus_wdata | output | DW | Write data |
| bus_gnt | input | 1 | Bus accepts the current cycle |
| bus_rdata | input | DW | Read data, valid with `bus_gnt` on a read |
| chan_en | output | NCH | Channel enable state |
| chan_done | output | NCH | Channel completed its count |
| chan_irq | output | NCH | One-cycle completion pulse |

## Verification
The hardest situation to reach is a higher-priority channel becoming pending while a lower one is already part-way through a burst. Only then does the rule that a burst is never preempted show up. The bench starts channel 3's burst and triggers channel 0 one cycle later, while channel 3 already holds the bus. It then checks the logged order of write addresses.

A pseudo-random stall on the grant stretches both read and write cycles throughout the run. The exhaustive sweep over channel, unit size and pointer modes therefore runs under changing bus timing. A small count width in the bench makes the zero-means-full-range count reachable within the run.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

   typedef struct packed {
      logic word;
      logic burst;
      logic src_inc;
      logic dst_inc;
      logic hw_trig;
   } chan_mode_t;

   typedef enum logic [1:0] {
      XS_IDLE  = 2'd0,
      XS_READ  = 2'd1,
      XS_WRITE = 2'd2
   } xfer_state_e;

endpackage

// File: rtl/dma_chan.sv
module dma_chan
   import dma4_pkg::*;
#(
   parameter int AW   = 24,
   parameter int CW   = 17,
   parameter int NIRQ = 4,
   localparam int SELW = $clog2(NIRQ)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_load,
   input  logic [AW-1:0]   cfg_src,
   input  logic [AW-1:0]   cfg_dst,
   input  logic [CW-1:0]   cfg_cnt,
   input  chan_mode_t      cfg_mode,
   input  logic [SELW-1:0] cfg_sel,
   input  logic            cfg_en,
   input  logic            sw_start,
   input  logic [NIRQ-1:0] irq_rise,
   input  logic            unit_done,
   output logic [AW-1:0]   src,
   output logic [AW-1:0]   dst,
   output chan_mode_t      mode,
   output logic            req,
   output logic            last,
   output logic            en,
   output logic            done,
   output logic            irq
);

   logic [CW-1:0]   cnt;
   logic [SELW-1:0] sel;
   logic            pend;
   logic            trig;
   logic [CW-1:0]   cnt_step;
   logic [AW-1:0]   ptr_step;

   assign cnt_step = mode.word ? CW'(2) : CW'(1);
   assign ptr_step = mode.word ? AW'(2) : AW'(1);
   assign last     = (cnt == cnt_step);
   assign trig     = en && (mode.hw_trig ? irq_rise[sel] : sw_start);
   assign req      = en && pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src  <= '0;
         dst  <= '0;
         cnt  <= '0;
         mode <= '0;
         sel  <= '0;
         en   <= 1'b0;
         done <= 1'b0;
         irq  <= 1'b0;
         pend <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (cfg_load) begin
            src  <= cfg_src;
            dst  <= cfg_dst;
            cnt  <= cfg_mode.word ? {cfg_cnt[CW-1:1], 1'b0} : cfg_cnt;
            mode <= cfg_mode;
            sel  <= cfg_sel;
            en   <= cfg_en;
            done <= 1'b0;
            pend <= 1'b0;
         end else if (unit_done) begin
            if (mode.src_inc) src <= src + ptr_step;
            if (mode.dst_inc) dst <= dst + ptr_step;
            cnt <= cnt - cnt_step;
            if (last) begin
               en   <= 1'b0;
               done <= 1'b1;
               irq  <= 1'b1;
               pend <= 1'b0;
            end else if (!mode.burst) begin
               pend <= trig;
            end
         end else if (trig) begin
            pend <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
   parameter int NCH = 4,
   localparam int CHW = $clog2(NCH)
) (
   input  logic [NCH-1:0] req,
   output logic           any,
   output logic [CHW-1:0] win
);

   always_comb begin
      win = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (req[i]) win = CHW'(i);
      end
   end

   assign any = |req;

endmodule

// File: rtl/dma_xfer.sv
module dma_xfer
   import dma4_pkg::*;
#(
   parameter int AW  = 24,
   parameter int DW  = 16,
   parameter int NCH = 4,
   localparam int CHW = $clog2(NCH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           any_req,
   input  logic [CHW-1:0] win,
   input  logic [AW-1:0]  src,
   input  logic [AW-1:0]  dst,
   input  logic           word,
   input  logic           burst,
   input  logic           last,
   input  logic           bus_gnt,
   input  logic [DW-1:0]  bus_rdata,
   output logic [CHW-1:0] cur,
   output logic           bus_req,
   output logic           bus_we,
   output logic           bus_word,
   output logic [AW-1:0]  bus_addr,
   output logic [DW-1:0]  bus_wdata,
   output logic           unit_done
);

   xfer_state_e   state;
   logic [DW-1:0] data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= XS_IDLE;
         cur   <= '0;
         data  <= '0;
      end else begin
         case (state)
            XS_IDLE: begin
               if (any_req) begin
                  cur   <= win;
                  state <= XS_READ;
               end
            end
            XS_READ: begin
               if (bus_gnt) begin
                  data  <= word ? bus_rdata : {{(DW-8){1'b0}}, bus_rdata[7:0]};
                  state <= XS_WRITE;
               end
            end
            XS_WRITE: begin
               if (bus_gnt) state <= (burst && !last) ? XS_READ : XS_IDLE;
            end
            default: state <= XS_IDLE;
         endcase
      end
   end

   assign bus_req   = (state != XS_IDLE);
   assign bus_we    = (state == XS_WRITE);
   assign bus_word  = word;
   assign bus_addr  = (state == XS_WRITE) ? dst : src;
   assign bus_wdata = data;
   assign unit_done = (state == XS_WRITE) && bus_gnt;

endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
   import dma4_pkg::*;
#(
   parameter int NCH  = 4,
   parameter int NIRQ = 4,
   parameter int AW   = 24,
   parameter int DW   = 16,
   parameter int CW   = 17
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_we,
   input  logic [$clog2(NCH)-1:0]  cfg_ch,
   input  logic [AW-1:0]           cfg_src,
   input  logic [AW-1:0]           cfg_dst,
   input  logic [CW-1:0]           cfg_cnt,
   input  logic                    cfg_word,
   input  logic                    cfg_burst,
   input  logic                    cfg_src_inc,
   input  logic                    cfg_dst_inc,
   input  logic                    cfg_hw_trig,
   input  logic [$clog2(NIRQ)-1:0] cfg_sel,
   input  logic                    cfg_en,
   input  logic [NCH-1:0]          sw_start,
   input  logic [NIRQ-1:0]         irq_req,
   output logic                    bus_req,
   output logic                    bus_we,
   output logic                    bus_word,
   output logic [AW-1:0]           bus_addr,
   output logic [DW-1:0]           bus_wdata,
   input  logic                    bus_gnt,
   input  logic [DW-1:0]           bus_rdata,
   output logic [NCH-1:0]          chan_en,
   output logic [NCH-1:0]          chan_done,
   output logic [NCH-1:0]          chan_irq
);

   localparam int CHW = $clog2(NCH);

   if (NCH < 2 || (1 << CHW) != NCH) begin : g_bad_nch
      $error("dma4_engine: NCH must be a power of two, at least 2");
   end
   if (NIRQ < 2 || (1 << $clog2(NIRQ)) != NIRQ) begin : g_bad_nirq
      $error("dma4_engine: NIRQ must be a power of two, at least 2");
   end
   if (DW != 16) begin : g_bad_dw
      $error("dma4_engine: DW must be 16");
   end
   if (CW < 2 || AW < 2) begin : g_bad_cw
      $error("dma4_engine: CW and AW must be at least 2");
   end

   logic [NIRQ-1:0] irq_q;
   logic [NIRQ-1:0] irq_rise;
   logic [AW-1:0]   src_a  [NCH];
   logic [AW-1:0]   dst_a  [NCH];
   chan_mode_t      mode_a [NCH];
   logic [NCH-1:0]  req_v;
   logic [NCH-1:0]  last_v;
   logic            any_req;
   logic [CHW-1:0]  win;
   logic [CHW-1:0]  cur;
   logic            unit_done;
   chan_mode_t      cfg_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= '0;
      else        irq_q <= irq_req;
   end
   assign irq_rise = irq_req & ~irq_q;

   assign cfg_mode = '{word: cfg_word, burst: cfg_burst, src_inc: cfg_src_inc,
                       dst_inc: cfg_dst_inc, hw_trig: cfg_hw_trig};

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      dma_chan #(.AW(AW), .CW(CW), .NIRQ(NIRQ)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .cfg_load  (cfg_we && (cfg_ch == CHW'(i))),
         .cfg_src   (cfg_src),
         .cfg_dst   (cfg_dst),
         .cfg_cnt   (cfg_cnt),
         .cfg_mode  (cfg_mode),
         .cfg_sel   (cfg_sel),
         .cfg_en    (cfg_en),
         .sw_start  (sw_start[i]),
         .irq_rise  (irq_rise),
         .unit_done (unit_done && (cur == CHW'(i))),
         .src       (src_a[i]),
         .dst       (dst_a[i]),
         .mode      (mode_a[i]),
         .req       (req_v[i]),
         .last      (last_v[i]),
         .en        (chan_en[i]),
         .done      (chan_done[i]),
         .irq       (chan_irq[i])
      );
   end

   dma_arb #(.NCH(NCH)) u_arb (
      .req (req_v),
      .any (any_req),
      .win (win)
   );

   dma_xfer #(.AW(AW), .DW(DW), .NCH(NCH)) u_xfer (
      .clk       (clk),
      .rst_n     (rst_n),
      .any_req   (any_req),
      .win       (win),
      .src       (src_a[cur]),
      .dst       (dst_a[cur]),
      .word      (mode_a[cur].word),
      .burst     (mode_a[cur].burst),
      .last      (last_v[cur]),
      .bus_gnt   (bus_gnt),
      .bus_rdata (bus_rdata),
      .cur       (cur),
      .bus_req   (bus_req),
      .bus_we    (bus_we),
      .bus_word  (bus_word),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .unit_done (unit_done)
   );

endmodule

// File: rtl/dma4_engine_chk.sv
module dma4_engine_chk #(
   parameter int NCH = 4,
   parameter int AW  = 24
) (
   input logic           clk,
   input logic           rst_n,
   input logic           bus_req,
   input logic           bus_gnt,
   input logic           bus_we,
   input logic           bus_word,
   input logic [AW-1:0]  bus_addr,
   input logic [NCH-1:0] chan_en,
   input logic [NCH-1:0] chan_done,
   input logic [NCH-1:0] chan_irq
);

   a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_gnt |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_word));

   a_r6_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_gnt && !bus_we |=> bus_req && bus_we);

   a_r11_one_completion: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chan_irq));

   for (genvar i = 0; i < NCH; i++) begin : g_chk
      a_r11_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
         chan_irq[i] |=> !chan_irq[i]);
      a_r11_irq_with_flags: assert property (@(posedge clk) disable iff (!rst_n)
         chan_irq[i] |-> chan_done[i] && !chan_en[i]);
   end

endmodule

bind dma4_engine dma4_engine_chk #(.NCH(NCH), .AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_req   (bus_req),
   .bus_gnt   (bus_gnt),
   .bus_we    (bus_we),
   .bus_word  (bus_word),
   .bus_addr  (bus_addr),
   .chan_en   (chan_en),
   .chan_done (chan_done),
   .chan_irq  (chan_irq)
);

// File: tb/dma4_engine_test.sv
module dma4_engine_test;

   localparam int NCH = 4, NIRQ = 4, AW = 8, DW = 16, CW = 6;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cfg_we = 1'b0;
   logic [1:0]     cfg_ch = '0;
   logic [AW-1:0]  cfg_src = '0, cfg_dst = '0;
   logic [CW-1:0]  cfg_cnt = '0;
   logic           cfg_word = 0, cfg_burst = 0, cfg_src_inc = 0, cfg_dst_inc = 0;
   logic           cfg_hw_trig = 0, cfg_en = 0;
   logic [1:0]     cfg_sel = '0;
   logic [NCH-1:0] sw_start = '0;
   logic [NIRQ-1:0] irq_req = '0;
   logic           bus_req, bus_we, bus_word, bus_gnt;
   logic [AW-1:0]  bus_addr;
   logic [DW-1:0]  bus_wdata, bus_rdata;
   logic [NCH-1:0] chan_en, chan_done, chan_irq;

   always #10 clk = ~clk;

   dma4_engine #(.NCH(NCH), .NIRQ(NIRQ), .AW(AW), .DW(DW), .CW(CW)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
      .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt),
      .cfg_word(cfg_word), .cfg_burst(cfg_burst), .cfg_src_inc(cfg_src_inc),
      .cfg_dst_inc(cfg_dst_inc), .cfg_hw_trig(cfg_hw_trig), .cfg_sel(cfg_sel),
      .cfg_en(cfg_en), .sw_start(sw_start), .irq_req(irq_req),
      .bus_req(bus_req), .bus_we(bus_we), .bus_word(bus_word),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_gnt(bus_gnt),
      .bus_rdata(bus_rdata), .chan_en(chan_en), .chan_done(chan_done),
      .chan_irq(chan_irq)
   );

   // Bus model: byte memory, stall from an LFSR.
   logic [7:0] mem [256];
   logic [7:0] exp_mem [256];
   logic [7:0] lfsr = 8'hA5;
   logic       fill_req = 1'b0;
   logic [7:0] fill_seed = '0;
   int         wr_cnt = 0;
   logic [7:0] wlog [512];
   logic       last_word = 1'b0;
   int         irq_cnt [NCH];
   int         tests = 0, fails = 0;
   bit         wd_fired = 0;

   assign bus_gnt   = bus_req && !(lfsr[0] && lfsr[3]);
   assign bus_rdata = bus_word ? {mem[8'(bus_addr + 8'd1)], mem[bus_addr]}
                               : {8'h00, mem[bus_addr]};

   always @(posedge clk) begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (fill_req) begin
         for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 13) ^ fill_seed;
      end else if (bus_req && bus_gnt && bus_we) begin
         mem[bus_addr] <= bus_wdata[7:0];
         if (bus_word) mem[8'(bus_addr + 8'd1)] <= bus_wdata[15:8];
      end
      if (bus_req && bus_gnt && bus_we) begin
         if (wr_cnt < 512) wlog[wr_cnt] <= bus_addr;
         wr_cnt    <= wr_cnt + 1;
         last_word <= bus_word;
      end
      for (int i = 0; i < NCH; i++) if (chan_irq[i]) irq_cnt[i] <= irq_cnt[i] + 1;
   end

   initial for (int i = 0; i < NCH; i++) irq_cnt[i] = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic fill(input logic [7:0] seed);
      @(negedge clk);
      fill_seed = seed;
      fill_req  = 1'b1;
      @(negedge clk);
      fill_req  = 1'b0;
      for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i * 13) ^ seed;
   endtask

   task automatic cfg(input int ch, input int src, input int dst, input int cnt,
                      input bit word, input bit burst, input bit si, input bit di,
                      input bit hw, input int sel, input bit en);
      @(negedge clk);
      cfg_ch = 2'(ch); cfg_src = 8'(src); cfg_dst = 8'(dst); cfg_cnt = 6'(cnt);
      cfg_word = word; cfg_burst = burst; cfg_src_inc = si; cfg_dst_inc = di;
      cfg_hw_trig = hw; cfg_sel = 2'(sel); cfg_en = en; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic kick(input logic [NCH-1:0] m);
      @(negedge clk);
      sw_start = m;
      @(negedge clk);
      sw_start = '0;
   endtask

   task automatic wait_writes(input int target);
      for (int n = 0; n < 3000 && wr_cnt < target; n++) @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   function automatic int units_of(input int cnt, input bit word);
      int c = word ? (cnt & ~1) : cnt;
      if (c == 0) c = 1 << CW;
      return word ? c / 2 : c;
   endfunction

   task automatic model(input int src, input int dst, input int units,
                        input bit word, input bit si, input bit di);
      int s = src, d = dst;
      for (int u = 0; u < units; u++) begin
         exp_mem[d & 255] = exp_mem[s & 255];
         if (word) exp_mem[(d + 1) & 255] = exp_mem[(s + 1) & 255];
         if (si) s += word ? 2 : 1;
         if (di) d += word ? 2 : 1;
      end
   endtask

   function automatic int mem_diff();
      int m = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) m++;
      return m;
   endfunction

   task automatic run_burst(input int ch, input bit word, input bit si, input bit di,
                            input int src, input int dst, input int cnt);
      int w0, i0, u;
      fill(8'(ch * 37 + cnt));
      u = units_of(cnt, word);
      model(src, dst, u, word, si, di);
      cfg(ch, src, dst, cnt, word, 1'b1, si, di, 1'b0, 0, 1'b1);
      w0 = wr_cnt; i0 = irq_cnt[ch];
      kick(4'(1 << ch));
      wait_writes(w0 + u);
      idle(4);
      chk(wr_cnt - w0 == u, "R8 R10 burst unit count", wr_cnt - w0, u);
      chk(mem_diff() == 0, "R5 R6 memory image mismatches", mem_diff(), 0);
      chk(last_word == word, "R4 bus_word", int'(last_word), int'(word));
      chk(chan_done[ch] && !chan_en[ch], "R11 done set, enable clear",
          int'({chan_done[ch], chan_en[ch]}), 2);
      chk(irq_cnt[ch] - i0 == 1, "R11 one completion pulse", irq_cnt[ch] - i0, 1);
   endtask

   // Watchdog
   initial begin
      for (int c = 0; c < 150000; c++) @(posedge clk);
      wd_fired = 1;
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int w0, i0;
      idle(3);
      @(negedge clk);
      chk(chan_en == 0 && chan_done == 0 && chan_irq == 0 && !bus_req,
          "R13 reset state", int'({chan_en, chan_done, chan_irq, bus_req}), 0);
      rst_n = 1'b1;
      idle(2);
      chk(!bus_req && chan_en == 0, "R13 quiet after reset", int'(bus_req), 0);

      // R1 R4 R5 R6 R8 R10: sweep channels, unit size, pointer modes
      for (int ch = 0; ch < NCH; ch++)
         for (int wd = 0; wd < 2; wd++)
            for (int sd = 0; sd < 4; sd++)
               for (int ci = 0; ci < 2; ci++)
                  run_burst(ch, wd[0], sd[1], sd[0], 8'h10 + ch, 8'h80, ci ? 6 : 3);

      // R10: zero count means 2^CW bytes, word mode ignores bit 0
      run_burst(2, 1'b1, 1'b1, 1'b1, 8'h00, 8'h80, 0);
      run_burst(1, 1'b1, 1'b1, 1'b1, 8'h20, 8'h90, 1);
      run_burst(0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h80, 0);

      // R8: single-unit mode, one unit per trigger
      fill(8'h5C);
      model(8'h30, 8'hA0, 3, 1'b0, 1'b1, 1'b1);
      cfg(2, 8'h30, 8'hA0, 3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 0, 1'b1);
      w0 = wr_cnt; i0 = irq_cnt[2];
      for (int t = 1; t <= 3; t++) begin
         kick(4'b0100);
         wait_writes(w0 + t);
         idle(12);
         chk(wr_cnt - w0 == t, "R8 single unit per trigger", wr_cnt - w0, t);
         chk(chan_done[2] == (t == 3), "R8 done only after last unit",
             int'(chan_done[2]), int'(t == 3));
      end
      chk(mem_diff() == 0, "R8 single-mode memory", mem_diff(), 0);
      chk(irq_cnt[2] - i0 == 1, "R11 single-mode completion", irq_cnt[2] - i0, 1);

      // R12: trigger on a channel disabled by completion
      w0 = wr_cnt;
      kick(4'b0100);
      idle(15);
      chk(wr_cnt == w0 && !chan_en[2], "R12 trigger after completion ignored", wr_cnt - w0, 0);

      // R12: trigger on a never-enabled channel
      cfg(3, 8'h10, 8'hC0, 4, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 0, 1'b0);
      w0 = wr_cnt;
      kick(4'b1000);
      idle(15);
      chk(wr_cnt == w0 && !bus_req, "R12 trigger while disabled ignored", wr_cnt - w0, 0);
      chk(!chan_done[3] && !chan_en[3], "R1 R12 disabled channel flags",
          int'({chan_done[3], chan_en[3]}), 0);

      // R3 R2: interrupt-line trigger
      fill(8'h71);
      model(8'h20, 8'h90, 2, 1'b0, 1'b1, 1'b1);
      cfg(1, 8'h20, 8'h90, 2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2, 1'b1);
      w0 = wr_cnt;
      @(negedge clk); irq_req[3] = 1'b1;
      idle(12); irq_req[3] = 1'b0;
      kick(4'b0010);
      idle(12);
      chk(wr_cnt == w0, "R3 R2 other line and software start ignored", wr_cnt - w0, 0);
      @(negedge clk); irq_req[2] = 1'b1;
      wait_writes(w0 + 1);
      idle(20);
      chk(wr_cnt - w0 == 1, "R3 held line triggers once", wr_cnt - w0, 1);
      @(negedge clk); irq_req[2] = 1'b0;
      @(negedge clk); irq_req[2] = 1'b1;
      wait_writes(w0 + 2);
      idle(8);
      irq_req[2] = 1'b0;
      chk(wr_cnt - w0 == 2 && chan_done[1], "R3 second edge completes", wr_cnt - w0, 2);
      chk(mem_diff() == 0, "R3 memory", mem_diff(), 0);

      // R9: simultaneous bursts, channel 0 first
      fill(8'h0F);
      cfg(0, 8'h10, 8'h80, 4, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 0, 1'b1);
      cfg(3, 8'h40, 8'hC0, 4, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 0, 1'b1);
      w0 = wr_cnt;
      kick(4'b1001);
      wait_writes(w0 + 8);
      idle(4);
      for (int k = 0; k < 8; k++)
         chk(wlog[w0 + k] == 8'((k < 4) ? 8'h80 + k : 8'hC0 + k - 4),
             "R9 priority order of writes", int'(wlog[w0 + k]),
             (k < 4) ? 8'h80 + k : 8'hC0 + k - 4);

      // R8 R9: running burst on channel 3 is not preempted by channel 0
      cfg(0, 8'h10, 8'h80, 4, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 0, 1'b1);
      cfg(3, 8'h40, 8'hC0, 4, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 0, 1'b1);
      w0 = wr_cnt;
      @(negedge clk); sw_start = 4'b1000;
      @(negedge clk); sw_start = 4'b0001;
      @(negedge clk); sw_start = 4'b0000;
      wait_writes(w0 + 8);
      idle(4);
      for (int k = 0; k < 8; k++)
         chk(wlog[w0 + k] == 8'((k < 4) ? 8'hC0 + k : 8'h80 + k - 4),
             "R8 burst holds bus", int'(wlog[w0 + k]),
             (k < 4) ? 8'hC0 + k : 8'h80 + k - 4);

      // R9: single-mode channels arbitrate per unit
      cfg(1, 8'h10, 8'hA0, 2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 0, 1'b1);
      cfg(3, 8'h40, 8'hB0, 2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 0, 1'b1);
      w0 = wr_cnt;
      kick(4'b1010);
      wait_writes(w0 + 2);
      idle(6);
      chk(wlog[w0] == 8'hA0 && wlog[w0 + 1] == 8'hB0, "R9 single-mode order",
          int'(wlog[w0]), 8'hA0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule